// File: doc/BRIEF.md
# Interleaved Host-to-Device Address Decoder

This block is the address decoder of a memory-expander endpoint. Software sets up a decode window through a 32-bit register port. The window has a 64-bit base, a 64-bit size and a control word. The control word holds the interleave granule and the way count. Software then commits the window through a handshake bit.

Once the window is committed, each incoming host physical address goes through one registered stage. The stage subtracts the base and checks the resulting offset against the window size. It then builds the device physical address. The granule bits of the offset stay in place, the way-selector bits just above them are dropped, and the remaining upper bits move down to close the gap.

An access that misses is flagged on the response. A miss is an address outside the window, a device address past the backing capacity, or any access while the window is not committed. A read that misses reports an error. A write that misses completes without error but never raises the memory write enable.

Top module: `ilvdec_top`

## Requirements
- R1: After reset, all five decoder registers read back as zero, and every request misses.
- R2: Register byte offsets are 0x00 base low, 0x04 base high, 0x08 size low, 0x0C size high and 0x10 control. A read strobe returns the addressed word on regRdData, with regRdValid high, one cycle later. Any other offset reads as zero.
- R3: A register write is ignored if any of the following holds: regByteEn is not 4'hF, regAddr[1:0] is not zero, or regAddr is at or beyond REGION_BYTES.
- R4: A control write with bit 9 (commit) set stores the written word with bit 9 cleared, bit 11 (error) cleared and bit 10 (committed) set.
- R5: A control write with bit 9 clear stores the word unchanged. Bits [3:0] are the granularity code ig and bits [7:4] are the way code iw.
- R6: On a hit, rspDpa is built from the offset (address minus base) in two parts. Offset bits below position g=8+ig keep their place. Offset bits at positions g+iw and above are shifted right by iw.
- R7: A host address below the base misses.
- R8: An offset greater than or equal to the programmed size misses.
- R9: A device address greater than or equal to CAP_BYTES misses.
- R10: rspValid is high exactly in the cycle after a cycle with reqValid high. In that cycle rspWrite, rspHit and rspDpa belong to that request.
- R11: A read miss raises rspErr. A write miss keeps rspErr and memWrEn low. A write hit raises memWrEn.
- R12: While control bit 10 is zero, every request misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register byte offset |
| regByteEn | input | 4 | Write byte enables; only 4'hF is accepted |
| regWrData | input | 32 | Register write data |
| regRdEn | input | 1 | Register read strobe |
| regRdValid | output | 1 | Read data valid, one cycle after regRdEn |
| regRdData | output | 32 | Register read data |
| reqValid | input | 1 | Translation request strobe |
| reqWrite | input | 1 | Request is a write |
| reqAddr | input | 64 | Host physical address |
| rspValid | output | 1 | Response strobe |
| rspWrite | output | 1 | Response belongs to a write |
| rspHit | output | 1 | Address decoded inside window and capacity |
| rspErr | output | 1 | Read miss error |
| rspDpa | output | 64 | Device physical address |
| memWrEn | output | 1 | Write hit, memory may be written |

## Verification
The bench builds the block with CAP_BYTES at 1 MiB instead of the default 4 GiB. With that value, window sizes of a few MiB can place translated addresses on both sides of the capacity limit, so the capacity miss can be reached. REGION_BYTES stays at 32 and REG_AW at 16. This keeps unmapped in-region offsets (0x14 to 0x1C) and out-of-region offsets (0x40) both reachable for the ignore and read-as-zero rules. Random windows use granule codes 0 to 3 and way codes 0 to 3. Bases are placed both below and above the 32-bit boundary, which exercises the carry between the high and low halves.

// File: rtl/ilvdec_pkg.sv
package ilvdec_pkg;

  localparam int REG_W    = 32;
  localparam int ADDR_W   = 2 * REG_W;
  localparam int GRAN_MIN = 8;

  // Register byte offsets
  localparam int OFF_BASE_LO = 'h00;
  localparam int OFF_BASE_HI = 'h04;
  localparam int OFF_SIZE_LO = 'h08;
  localparam int OFF_SIZE_HI = 'h0C;
  localparam int OFF_CTRL    = 'h10;

  // Control word layout
  localparam int IG_LSB        = 0;
  localparam int IG_W          = 4;
  localparam int IW_LSB        = 4;
  localparam int IW_W          = 4;
  localparam int COMMIT_BIT    = 9;
  localparam int COMMITTED_BIT = 10;
  localparam int ERR_BIT       = 11;

  // Settings handed from the register side to the translation datapath
  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] size;
    logic [IG_W-1:0]   ig;
    logic [IW_W-1:0]   iw;
    logic              enable;
  } ilvdec_cfg_t;

endpackage

// File: rtl/ilvdec_regs.sv
module ilvdec_regs
  import ilvdec_pkg::*;
#(
  parameter int REG_AW       = 16,
  parameter int REGION_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              regRdEn,
  output logic              regRdValid,
  output logic [REG_W-1:0]  regRdData,
  output ilvdec_cfg_t       cfg
);

  localparam int NUM_WORDS = 5;

  logic [REG_W-1:0] regsQ [NUM_WORDS];
  logic             inRegion;
  logic             aligned;
  logic             wrAccept;
  logic [REG_W-1:0] ctrlNext;
  logic [REG_W-1:0] rdMux;

  assign inRegion = 32'(regAddr) < 32'(REGION_BYTES);
  assign aligned  = (regAddr[1:0] == 2'b00);
  assign wrAccept = regWrEn && (regByteEn == 4'hF) && aligned && inRegion;

  // Commit handshake: store the word, then retire commit/error and mark committed
  always_comb begin
    ctrlNext = regWrData;
    if (regWrData[COMMIT_BIT]) begin
      ctrlNext[COMMIT_BIT]    = 1'b0;
      ctrlNext[ERR_BIT]       = 1'b0;
      ctrlNext[COMMITTED_BIT] = 1'b1;
    end
  end

  generate
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam int WOFF = 4 * w;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regsQ[w] <= '0;
        end else if (wrAccept && (32'(regAddr) == WOFF)) begin
          if (WOFF == OFF_CTRL) regsQ[w] <= ctrlNext;
          else                  regsQ[w] <= regWrData;
        end
      end
    end
  endgenerate

  always_comb begin
    rdMux = '0;
    if (inRegion && aligned) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (32'(regAddr) == 4 * w) rdMux = regsQ[w];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdValid <= 1'b0;
      regRdData  <= '0;
    end else begin
      regRdValid <= regRdEn;
      regRdData  <= regRdEn ? rdMux : '0;
    end
  end

  always_comb begin
    cfg.base   = {regsQ[OFF_BASE_HI/4], regsQ[OFF_BASE_LO/4]};
    cfg.size   = {regsQ[OFF_SIZE_HI/4], regsQ[OFF_SIZE_LO/4]};
    cfg.ig     = regsQ[OFF_CTRL/4][IG_LSB +: IG_W];
    cfg.iw     = regsQ[OFF_CTRL/4][IW_LSB +: IW_W];
    cfg.enable = regsQ[OFF_CTRL/4][COMMITTED_BIT];
  end

endmodule

// File: rtl/ilvdec_xlate.sv
module ilvdec_xlate
  import ilvdec_pkg::*;
#(
  parameter logic [63:0] CAP_BYTES = 64'h0000_0001_0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ilvdec_cfg_t       cfg,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspWrite,
  output logic              rspHit,
  output logic              rspErr,
  output logic [ADDR_W-1:0] rspDpa,
  output logic              memWrEn
);

  localparam int SH_W = $clog2(ADDR_W);

  logic              belowBase;
  logic [ADDR_W-1:0] offset;
  logic              inWindow;
  logic [SH_W-1:0]   granBits;
  logic [SH_W-1:0]   dropTop;
  logic [ADDR_W-1:0] lowMask;
  logic [ADDR_W-1:0] dpaD;
  logic              inCap;
  logic              hitD;

  always_comb begin
    belowBase = reqAddr < cfg.base;
    offset    = reqAddr - cfg.base;
    inWindow  = !belowBase && (offset < cfg.size);
    granBits  = SH_W'(GRAN_MIN) + SH_W'(cfg.ig);
    dropTop   = granBits + SH_W'(cfg.iw);
    lowMask   = (ADDR_W'(1) << granBits) - ADDR_W'(1);
    dpaD      = (offset & lowMask) | ((offset >> dropTop) << granBits);
    inCap     = dpaD < CAP_BYTES;
    hitD      = cfg.enable && inWindow && inCap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspWrite <= 1'b0;
      rspHit   <= 1'b0;
      rspErr   <= 1'b0;
      rspDpa   <= '0;
      memWrEn  <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspWrite <= reqValid && reqWrite;
      rspHit   <= reqValid && hitD;
      rspErr   <= reqValid && !reqWrite && !hitD;
      rspDpa   <= (reqValid && hitD) ? dpaD : '0;
      memWrEn  <= reqValid && reqWrite && hitD;
    end
  end

endmodule

// File: rtl/ilvdec_top.sv
module ilvdec_top
  import ilvdec_pkg::*;
#(
  parameter int          REG_AW       = 16,
  parameter int          REGION_BYTES = 32,
  parameter logic [63:0] CAP_BYTES    = 64'h0000_0001_0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [31:0]       regWrData,
  input  logic              regRdEn,
  output logic              regRdValid,
  output logic [31:0]       regRdData,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [63:0]       reqAddr,
  output logic              rspValid,
  output logic              rspWrite,
  output logic              rspHit,
  output logic              rspErr,
  output logic [63:0]       rspDpa,
  output logic              memWrEn
);

  ilvdec_cfg_t cfg;

  ilvdec_regs #(
    .REG_AW       (REG_AW),
    .REGION_BYTES (REGION_BYTES)
  ) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regByteEn  (regByteEn),
    .regWrData  (regWrData),
    .regRdEn    (regRdEn),
    .regRdValid (regRdValid),
    .regRdData  (regRdData),
    .cfg        (cfg)
  );

  ilvdec_xlate #(
    .CAP_BYTES (CAP_BYTES)
  ) u_xlate (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .rspValid (rspValid),
    .rspWrite (rspWrite),
    .rspHit   (rspHit),
    .rspErr   (rspErr),
    .rspDpa   (rspDpa),
    .memWrEn  (memWrEn)
  );

endmodule

// File: rtl/ilvdec_chk.sv
module ilvdec_chk
  import ilvdec_pkg::*;
#(
  parameter int          REG_AW    = 16,
  parameter logic [63:0] CAP_BYTES = 64'h0000_0001_0000_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [3:0]        regByteEn,
  input logic [31:0]       regWrData,
  input logic              reqValid,
  input logic              rspValid,
  input logic              rspWrite,
  input logic              rspHit,
  input logic              rspErr,
  input logic [63:0]       rspDpa,
  input logic              memWrEn,
  input ilvdec_cfg_t       cfg
);

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R10
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R4
  commit_sets_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == REG_AW'(OFF_CTRL) && regByteEn == 4'hF && regWrData[COMMIT_BIT])
    |=> cfg.enable);

  // R3
  partial_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regByteEn != 4'hF) |=> ($stable(cfg.base) && $stable(cfg.size) &&
                                         $stable(cfg.ig) && $stable(cfg.iw) && $stable(cfg.enable)));

  // R12
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> $past(cfg.enable));

  // R9
  hit_within_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (rspDpa < CAP_BYTES));

  // R11
  err_only_read_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspValid && !rspWrite && !rspHit));

  // R11
  memwr_only_write_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (rspValid && rspWrite && rspHit));

endmodule

bind ilvdec_top ilvdec_chk #(
  .REG_AW    (REG_AW),
  .CAP_BYTES (CAP_BYTES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regByteEn (regByteEn),
  .regWrData (regWrData),
  .reqValid  (reqValid),
  .rspValid  (rspValid),
  .rspWrite  (rspWrite),
  .rspHit    (rspHit),
  .rspErr    (rspErr),
  .rspDpa    (rspDpa),
  .memWrEn   (memWrEn),
  .cfg       (cfg)
);

// File: tb/ilvdec_top_tb.sv
`timescale 1ns/1ps
module ilvdec_top_tb;

  localparam int          REG_AW = 16;
  localparam int          REGION = 32;
  localparam logic [63:0] CAP    = 64'h0000_0000_0010_0000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [REG_AW-1:0] regAddr = '0;
  logic [3:0]        regByteEn = '0;
  logic [31:0]       regWrData = '0;
  logic              regRdEn = 1'b0;
  logic              regRdValid;
  logic [31:0]       regRdData;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [63:0]       reqAddr = '0;
  logic              rspValid, rspWrite, rspHit, rspErr, memWrEn;
  logic [63:0]       rspDpa;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the registers
  logic [63:0] mBase = '0;
  logic [63:0] mSize = '0;
  logic [31:0] mCtrl = '0;

  always #2.5 clk = ~clk;

  ilvdec_top #(.REG_AW(REG_AW), .REGION_BYTES(REGION), .CAP_BYTES(CAP)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regByteEn(regByteEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdValid(regRdValid), .regRdData(regRdData), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .rspValid(rspValid),
    .rspWrite(rspWrite), .rspHit(rspHit), .rspErr(rspErr), .rspDpa(rspDpa),
    .memWrEn(memWrEn));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected translation, bit by bit from the R6..R9, R12 rules
  function automatic logic [64:0] refXlate(input logic [63:0] a);
    logic [63:0] off, d;
    int g, w;
    if (!mCtrl[10] || a < mBase) return '0;
    off = a - mBase;
    if (off >= mSize) return '0;
    g = 8 + int'(mCtrl[3:0]);
    w = int'(mCtrl[7:4]);
    d = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < g) d[i] = off[i];
      else if (i + w < 64) d[i] = off[i + w];
    end
    if (d >= CAP) return '0;
    return {1'b1, d};
  endfunction

  task automatic regWrite(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d; regByteEn = be;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = '0;
    if (be == 4'hF && a[1:0] == 2'b00 && a < 16'(REGION)) begin
      case (a)
        16'h00: mBase[31:0]  = d;
        16'h04: mBase[63:32] = d;
        16'h08: mSize[31:0]  = d;
        16'h0C: mSize[63:32] = d;
        16'h10: mCtrl = d[9] ? ((d & ~32'h0000_0A00) | 32'h0000_0400) : d;
        default: ;
      endcase
    end
  endtask

  task automatic regCheck(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    check(regRdValid && regRdData == exp, tag, {31'd0, regRdValid, regRdData}, {32'd1, exp});
  endtask

  task automatic setWindow(input logic [63:0] b, input logic [63:0] s, input logic [31:0] c);
    regWrite(16'h00, b[31:0], 4'hF);
    regWrite(16'h04, b[63:32], 4'hF);
    regWrite(16'h08, s[31:0], 4'hF);
    regWrite(16'h0C, s[63:32], 4'hF);
    regWrite(16'h10, c, 4'hF);
  endtask

  // single request, checked one cycle later
  task automatic request(input logic [63:0] a, input bit wr, input string tag);
    logic [64:0] e;
    e = refXlate(a);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid && rspWrite == wr && rspHit == e[64] && (!e[64] || rspDpa == e[63:0]) &&
          rspErr == (!wr && !e[64]) && memWrEn == (wr && e[64]),
          tag, {rspHit, rspErr, memWrEn, rspDpa[60:0]}, {e[64], !wr && !e[64], wr && e[64], e[60:0]});
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected done", wd);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [64:0] pend;
    bit pendV, pendW;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regCheck(16'h00, 32'h0, "R1 base lo");
    regCheck(16'h04, 32'h0, "R1 base hi");
    regCheck(16'h08, 32'h0, "R1 size lo");
    regCheck(16'h0C, 32'h0, "R1 size hi");
    regCheck(16'h10, 32'h0, "R1 ctrl");
    request(64'h0, 1'b0, "R1 miss after reset");

    // R12 window programmed but not committed
    setWindow(64'h0000_0001_0000_0000, 64'h0000_0000_0004_0000, 32'h0000_0010);
    request(64'h0000_0001_0000_0010, 1'b0, "R12 uncommitted read misses");

    // R4 commit handshake with error bit written
    regWrite(16'h10, 32'h0000_0A10, 4'hF);
    regCheck(16'h10, 32'h0000_0410, "R4 commit clears 9/11 sets 10");

    // R2 readback and unmapped offset
    regCheck(16'h04, 32'h0000_0001, "R2 base hi");
    regCheck(16'h08, 32'h0004_0000, "R2 size lo");
    regCheck(16'h14, 32'h0, "R2 unmapped reads zero");

    // R3 ignored writes
    regWrite(16'h00, 32'hDEAD_BEEF, 4'h3);
    regCheck(16'h00, 32'h0, "R3 partial byte enable ignored");
    regWrite(16'h01, 32'hDEAD_BEEF, 4'hF);
    regCheck(16'h00, 32'h0, "R3 misaligned ignored");
    regWrite(16'h40, 32'hDEAD_BEEF, 4'hF);
    regCheck(16'h40, 32'h0, "R3 out of region ignored");
    request(64'h0000_0001_0000_01FF, 1'b0, "R3 window unchanged after ignored writes");

    // R6 translation, R7 below base, R8 size edge, R11 responses
    request(64'h0000_0001_0000_03FF, 1'b0, "R6 ig0 iw1 translate");
    request(64'h0000_0000_FFFF_FFFF, 1'b0, "R7 below base read error");
    request(64'h0000_0000_FFFF_FFFF, 1'b1, "R11 write miss dropped");
    request(64'h0000_0001_0004_0000, 1'b0, "R8 offset equal size misses");
    request(64'h0000_0001_0003_FFFF, 1'b1, "R8 last byte hits, R11 write hit");

    // R9 capacity edge with iw 0
    setWindow(64'h0000_0000_0020_0000, 64'h0000_0000_0040_0000, 32'h0000_0200);
    request(64'h0000_0000_002F_FFFF, 1'b0, "R9 last byte below capacity");
    request(64'h0000_0000_0030_0000, 1'b0, "R9 capacity reached misses");

    // R5 plain control writes
    regWrite(16'h10, 32'h0000_0023, 4'hF);
    regCheck(16'h10, 32'h0000_0023, "R5 verbatim store");
    request(64'h0000_0000_0020_0100, 1'b0, "R5 committed cleared misses");
    regWrite(16'h10, 32'h0000_0C23, 4'hF);
    regCheck(16'h10, 32'h0000_0C23, "R5 verbatim store with bit 10");
    request(64'h0000_0000_0020_1234, 1'b1, "R5 ig3 iw2 translate");

    // random windows, back-to-back requests (R6..R11)
    for (int cfgN = 0; cfgN < 10; cfgN++) begin
      logic [63:0] b, s;
      b = {($urandom_range(0, 1) == 1) ? 32'd2 : 32'd0, $urandom & 32'hFFFF_F000};
      s = 64'($urandom_range(1, 32'h0030_0000));
      setWindow(b, s, {20'd0, 2'b00, 1'b1, 1'b0, 2'b00, 2'($urandom), 2'b00, 2'($urandom)});
      pendV = 0; pendW = 0; pend = '0;
      for (int n = 0; n < 300; n++) begin
        logic [63:0] a;
        bit v, w;
        @(negedge clk);
        if (pendV) begin
          check(rspValid && rspWrite == pendW && rspHit == pend[64] &&
                (!pend[64] || rspDpa == pend[63:0]) && rspErr == (!pendW && !pend[64]) &&
                memWrEn == (pendW && pend[64]),
                "R6/R10/R11 random", {rspHit, rspErr, memWrEn, rspDpa[60:0]},
                {pend[64], !pendW && !pend[64], pendW && pend[64], pend[60:0]});
        end else begin
          check(!rspValid, "R10 idle no response", {63'd0, rspValid}, 64'd0);
        end
        v = ($urandom_range(0, 7) != 0);
        w = $urandom_range(0, 1) == 1;
        case ($urandom_range(0, 3))
          0: a = b - 64'($urandom_range(1, 4096));
          1: a = b + s - 64'($urandom_range(0, 3));
          default: a = b + 64'($urandom_range(0, 32'h0040_0000));
        endcase
        reqValid = v; reqWrite = w; reqAddr = a;
        pendV = v; pendW = w; pend = refXlate(a);
      end
      @(negedge clk);
      reqValid = 1'b0;
      if (pendV) begin
        check(rspValid && rspHit == pend[64], "R10 last random", {63'd0, rspHit}, {63'd0, pend[64]});
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule